// File: doc/BRIEF.md
# Program Counter Sequencer with Interrupt Vectoring

This block holds the 10-bit program counter of a small microcontroller and decides, every cycle, where it goes next. A simplified instruction stream presents one command at a time on a valid/ready port: advance by one, jump, call, return, or return-from-interrupt. A hardware return stack of four entries holds the addresses that calls and accepted interrupts push.

Three interrupt sources feed the block as request pulses: an external pin (bit 0), a timer overflow (bit 1) and an end-of-conversion event (bit 2). Each pulse is latched in a pending flag. A pending flag is serviced only when its per-source enable and the global enable are both set and the return stack still has room. An accepted interrupt pushes the current program counter, loads the source's fixed vector and stalls the command port for that cycle. Back-pressure rule: `cmd_ready` is low exactly in the cycles where an interrupt is accepted; a command is consumed only on a cycle with both `cmd_valid` and `cmd_ready` high, and the source must hold it unchanged until then.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, `pc_o` is 000h, `gie_o` is 0, `pending_o` is 0 and the return stack is empty (`stk_full_o` 0).
- R2: An accepted increment command adds one to the program counter, wrapping from 3FFh to 000h; with no accepted command the program counter holds.
- R3: An accepted jump loads `cmd_target`; an accepted call pushes the program counter plus one (wrapping) and loads `cmd_target`.
- R4: An accepted return loads the top stack entry and pops it; a return on an empty stack loads 000h.
- R5: The stack is last-in first-out with four entries; `stk_full_o` is 1 when four are held; a call on a full stack discards the oldest entry and keeps the four newest.
- R6: A request pulse sets its pending bit at the next clock edge; the bit stays set until that source is serviced, and a new request in the servicing cycle leaves it set.
- R7: An interrupt is accepted (`irq_ack` high) in a cycle exactly when `gie_o` is 1, some pending bit has its enable set, and the stack is not full; otherwise the request stays pending.
- R8: Acceptance loads 004h for bit 0, 008h for bit 1 and 00Ch for bit 2, and pushes the current program counter, the address of the command that was held back.
- R9: With several eligible sources, the lowest bit index is serviced first.
- R10: In an accepting cycle `cmd_ready` is 0, and at the next edge `gie_o` clears and the serviced pending bit clears.
- R11: An accepted return-from-interrupt behaves as a return and also sets `gie_o`.
- R12: `gie_clr` clears `gie_o`, `gie_set` sets it, clear wins over set and over return-from-interrupt, and interrupt acceptance clears it over all of them.
- R13: `cmd_op` encodes 0 increment, 1 jump, 2 call, 3 return, 4 return-from-interrupt; codes 5 to 7 are accepted and leave the program counter and stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 3 | Command code |
| cmd_target | input | 10 | Jump or call destination |
| irq_req | input | 3 | Request pulses: bit 0 external, bit 1 timer, bit 2 conversion |
| irq_en | input | 3 | Per-source enables |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| pc_o | output | 10 | Program counter |
| gie_o | output | 1 | Global interrupt enable |
| pending_o | output | 3 | Latched request flags |
| stk_full_o | output | 1 | Return stack holds four entries |

## Verification
The assertions take for granted that every input is settled before the rising edge and that reset is held over the first edges, so the stack depth and pending flags start from known values. The return-from-interrupt property assumes no simultaneous `gie_clr`, and it is stated with that exclusion. The stimulus changes inputs only on the falling edge, holds reset for several cycles, and draws command codes across all eight values, so reserved codes, returns on an empty stack and calls on a full stack all occur alongside requests that arrive while the stack is full or the enables are off.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Command codes on the instruction port
  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4
  } pc_op_e;

endpackage

// File: rtl/pcseq_irq_ctrl.sv
module pcseq_irq_ctrl #(
  parameter int N_SRC     = 3,
  parameter int PC_W      = 10,
  parameter int VEC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             stk_full,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             reti_fire,
  output logic             take,
  output logic [PC_W-1:0]  vec_addr,
  output logic [N_SRC-1:0] pending,
  output logic             gie
);

  logic [N_SRC-1:0] eligible;
  logic [N_SRC-1:0] grant;
  logic [N_SRC-1:0] serviced;
  logic [N_SRC:0]   seen;

  assign eligible = pending & irq_en;
  assign seen[0]  = 1'b0;

  // Lowest index wins: a source is granted when no lower one is eligible
  for (genvar i = 0; i < N_SRC; i++) begin : g_pri
    assign grant[i]    = eligible[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | eligible[i];
  end

  assign take     = gie & seen[N_SRC] & ~stk_full;
  assign serviced = take ? grant : '0;

  always_comb begin
    vec_addr = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) vec_addr = PC_W'((i + 1) << VEC_SHIFT);
    end
  end

  // A fresh request wins over the clear of the serviced flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~serviced) | irq_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gie <= 1'b0;
    else if (take)                  gie <= 1'b0;
    else if (gie_clr)               gie <= 1'b0;
    else if (gie_set || reti_fire)  gie <= 1'b1;
  end

endmodule

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_data,
  output logic [PC_W-1:0] top,
  output logic            full
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  ent [DEPTH];
  logic [CNT_W-1:0] cnt;

  // Shift-register stack: push moves entries deeper, pop pulls them up
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [PC_W-1:0] from_above;
    logic [PC_W-1:0] from_below;
    if (i == 0) begin : g_first
      assign from_above = push_data;
    end else begin : g_rest
      assign from_above = ent[i - 1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign from_below = '0;
    end else begin : g_inner
      assign from_below = ent[i + 1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ent[i] <= '0;
      else if (push) ent[i] <= from_above;
      else if (pop)  ent[i] <= from_below;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (push) begin
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (pop) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign top  = ent[0];
  assign full = (cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/pcseq_next_pc.sv
module pcseq_next_pc
  import pcseq_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic [PC_W-1:0] pc,
  input  logic            take,
  input  logic [PC_W-1:0] vec_addr,
  input  logic            cmd_fire,
  input  logic [2:0]      op,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] stk_top,
  output logic [PC_W-1:0] pc_next,
  output logic            push,
  output logic [PC_W-1:0] push_data,
  output logic            pop,
  output logic            reti_fire
);

  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc + 1'b1;

  always_comb begin
    pc_next   = pc;
    push      = 1'b0;
    push_data = pc;
    pop       = 1'b0;
    reti_fire = 1'b0;
    if (take) begin
      pc_next   = vec_addr;
      push      = 1'b1;
      push_data = pc;
    end else if (cmd_fire) begin
      case (pc_op_e'(op))
        OP_INC:  pc_next = pc_inc;
        OP_JMP:  pc_next = target;
        OP_CALL: begin
          push      = 1'b1;
          push_data = pc_inc;
          pc_next   = target;
        end
        OP_RET: begin
          pop     = 1'b1;
          pc_next = stk_top;
        end
        OP_RETI: begin
          pop       = 1'b1;
          pc_next   = stk_top;
          reti_fire = 1'b1;
        end
        default: pc_next = pc;
      endcase
    end
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int PC_W      = 10,
  parameter int N_SRC     = 3,
  parameter int STK_DEPTH = 4,
  parameter int VEC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [PC_W-1:0]  cmd_target,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             gie_set,
  input  logic             gie_clr,
  output logic             irq_ack,
  output logic [PC_W-1:0]  pc_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] pending_o,
  output logic             stk_full_o
);

  logic            take;
  logic [PC_W-1:0] vec_addr;
  logic            stk_full;
  logic [PC_W-1:0] stk_top;
  logic            push;
  logic            pop;
  logic [PC_W-1:0] push_data;
  logic            reti_fire;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_next;
  logic            cmd_fire;

  assign cmd_ready = ~take;
  assign cmd_fire  = cmd_valid & cmd_ready;

  pcseq_irq_ctrl #(
    .N_SRC(N_SRC), .PC_W(PC_W), .VEC_SHIFT(VEC_SHIFT)
  ) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .stk_full(stk_full), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti_fire(reti_fire), .take(take), .vec_addr(vec_addr),
    .pending(pending_o), .gie(gie_o)
  );

  pcseq_ret_stack #(
    .PC_W(PC_W), .DEPTH(STK_DEPTH)
  ) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_data(push_data), .top(stk_top), .full(stk_full)
  );

  pcseq_next_pc #(
    .PC_W(PC_W)
  ) u_nxt (
    .pc(pc_q), .take(take), .vec_addr(vec_addr), .cmd_fire(cmd_fire),
    .op(cmd_op), .target(cmd_target), .stk_top(stk_top),
    .pc_next(pc_next), .push(push), .push_data(push_data),
    .pop(pop), .reti_fire(reti_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc_o       = pc_q;
  assign irq_ack    = take;
  assign stk_full_o = stk_full;

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int PC_W      = 10,
  parameter int N_SRC     = 3,
  parameter int VEC_SHIFT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [PC_W-1:0]  cmd_target,
  input logic [N_SRC-1:0] irq_en,
  input logic             gie_clr,
  input logic             irq_ack,
  input logic [PC_W-1:0]  pc_o,
  input logic             gie_o,
  input logic [N_SRC-1:0] pending_o,
  input logic             stk_full_o
);

  localparam logic [PC_W-1:0] VEC_END = PC_W'((N_SRC + 1) << VEC_SHIFT);

  assert_ack_stalls_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !cmd_ready);

  assert_ack_conditions_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (gie_o && !stk_full_o && (|(pending_o & irq_en))));

  assert_vector_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (pc_o != '0 && pc_o < VEC_END && pc_o[VEC_SHIFT-1:0] == '0));

  assert_gie_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie_o);

  assert_pending_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |=> ((pending_o & $past(pending_o)) == $past(pending_o)));

  assert_reti_sets_gie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd4 && !gie_clr) |=> gie_o);

  assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd1) |=> (pc_o == $past(cmd_target)));

  assert_first_source_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && pending_o[0] && irq_en[0]) |=> (pc_o == PC_W'(1 << VEC_SHIFT)));

endmodule

bind pc_sequencer pcseq_checker #(
  .PC_W(PC_W), .N_SRC(N_SRC), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_target(cmd_target), .irq_en(irq_en),
  .gie_clr(gie_clr), .irq_ack(irq_ack), .pc_o(pc_o), .gie_o(gie_o),
  .pending_o(pending_o), .stk_full_o(stk_full_o)
);

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [9:0] cmd_target = 10'd0;
  logic [2:0] irq_req = 3'd0;
  logic [2:0] irq_en = 3'd0;
  logic       gie_set = 1'b0;
  logic       gie_clr = 1'b0;
  logic       irq_ack;
  logic [9:0] pc_o;
  logic       gie_o;
  logic [2:0] pending_o;
  logic       stk_full_o;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_target(cmd_target), .irq_req(irq_req),
    .irq_en(irq_en), .gie_set(gie_set), .gie_clr(gie_clr),
    .irq_ack(irq_ack), .pc_o(pc_o), .gie_o(gie_o),
    .pending_o(pending_o), .stk_full_o(stk_full_o)
  );

  // Reference state, kept from the requirements
  logic [9:0] m_pc;
  logic       m_gie;
  logic [2:0] m_pend;
  logic [9:0] m_stk [4];
  int         m_depth;

  task automatic chk(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [9:0] vec_of(input int idx);
    return 10'((idx + 1) * 4);
  endfunction

  function automatic int pick(input logic [2:0] elig);
    for (int i = 0; i < 3; i++) if (elig[i]) return i;
    return -1;
  endfunction

  task automatic m_push(input logic [9:0] v);
    for (int i = 3; i > 0; i--) m_stk[i] = m_stk[i - 1];
    m_stk[0] = v;
    if (m_depth < 4) m_depth++;
  endtask

  task automatic m_pop(output logic [9:0] v);
    v = m_stk[0];
    for (int i = 0; i < 3; i++) m_stk[i] = m_stk[i + 1];
    m_stk[3] = 10'd0;
    if (m_depth > 0) m_depth--;
  endtask

  task automatic m_reset();
    m_pc = 10'd0; m_gie = 1'b0; m_pend = 3'd0; m_depth = 0;
    for (int i = 0; i < 4; i++) m_stk[i] = 10'd0;
  endtask

  function automatic logic m_take();
    return m_gie && ((m_pend & irq_en) != 3'd0) && (m_depth < 4);
  endfunction

  // One clock cycle: drive at the falling edge, check combinational
  // outputs, advance the model at the rising edge, check registers after it.
  task automatic cycle(input logic v, input logic [2:0] op, input logic [9:0] tgt,
                       input logic [2:0] req, input logic [2:0] en,
                       input logic gs, input logic gc);
    logic       tk;
    int         sel;
    logic [2:0] svc;
    logic [9:0] popv;
    string      tag;
    cmd_valid = v; cmd_op = op; cmd_target = tgt;
    irq_req = req; irq_en = en; gie_set = gs; gie_clr = gc;
    #1;
    tk  = m_take();
    sel = pick(m_pend & en);
    chk(irq_ack, tk, "R7 irq_ack");
    chk(cmd_ready, !tk, "R10 cmd_ready");
    @(posedge clk);
    svc = tk ? 3'(1 << sel) : 3'd0;
    tag = "R2 pc";
    if (tk) begin
      m_push(m_pc);
      m_pc = vec_of(sel);
      tag  = "R8 pc";
    end else if (v) begin
      case (op)
        3'd0: begin m_pc = m_pc + 10'd1; tag = "R2 pc"; end
        3'd1: begin m_pc = tgt; tag = "R3 pc"; end
        3'd2: begin m_push(m_pc + 10'd1); m_pc = tgt; tag = "R3 pc"; end
        3'd3: begin m_pop(popv); m_pc = popv; tag = "R4 pc"; end
        3'd4: begin m_pop(popv); m_pc = popv; tag = "R11 pc"; end
        default: tag = "R13 pc";
      endcase
    end
    if (tk) m_gie = 1'b0;
    else if (gc) m_gie = 1'b0;
    else if (gs || (v && op == 3'd4)) m_gie = 1'b1;
    m_pend = (m_pend & ~svc) | req;
    @(negedge clk);
    chk(pc_o, m_pc, tag);
    chk(gie_o, m_gie, "R12 gie");
    chk(pending_o, m_pend, "R6 pending");
    chk(stk_full_o, (m_depth == 4), "R5 stk_full");
  endtask

  task automatic idle(input logic [2:0] en);
    cycle(1'b0, 3'd0, 10'd0, 3'd0, en, 1'b0, 1'b0);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [9:0] tgt);
    cycle(1'b1, op, tgt, 3'd0, 3'd0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    m_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pc_o, 0, "R1 pc at reset");
    chk(gie_o, 0, "R1 gie at reset");
    chk(pending_o, 0, "R1 pending at reset");
    chk(stk_full_o, 0, "R1 stack at reset");
    rst_n = 1'b1;
    idle(3'd0);
    chk(pc_o, 0, "R1 pc after release");

    // R2: wrap at the top of the address space
    cmd(3'd1, 10'h3FF);
    cmd(3'd0, 10'd0);
    chk(pc_o, 10'h000, "R2 wrap to 000h");
    // R4: return on empty stack
    cmd(3'd1, 10'h123);
    cmd(3'd3, 10'd0);
    chk(pc_o, 10'h000, "R4 empty return");
    // R13: reserved code holds
    cmd(3'd1, 10'h0AA);
    cmd(3'd6, 10'h155);
    chk(pc_o, 10'h0AA, "R13 reserved code");

    // R5: fill, overflow, unwind
    cmd(3'd1, 10'h010);
    cmd(3'd2, 10'h020);
    cmd(3'd2, 10'h030);
    cmd(3'd2, 10'h040);
    cmd(3'd2, 10'h050);
    chk(stk_full_o, 1, "R5 full after four calls");
    cmd(3'd2, 10'h060);
    cmd(3'd3, 10'd0);
    chk(pc_o, 10'h051, "R5 newest entry");
    cmd(3'd3, 10'd0);
    cmd(3'd3, 10'd0);
    cmd(3'd3, 10'd0);
    chk(pc_o, 10'h021, "R5 fourth entry kept");
    cmd(3'd3, 10'd0);
    chk(pc_o, 10'h000, "R5 oldest entry discarded");

    // R7: request blocked by a full stack stays pending
    cmd(3'd1, 10'h100);
    cmd(3'd2, 10'h110);
    cmd(3'd2, 10'h120);
    cmd(3'd2, 10'h130);
    cmd(3'd2, 10'h140);
    cycle(1'b0, 3'd0, 10'd0, 3'b001, 3'b111, 1'b1, 1'b0);
    idle(3'b111);
    idle(3'b111);
    chk(pending_o, 3'b001, "R7 blocked request kept");
    chk(pc_o, 10'h140, "R7 no vector while full");
    cycle(1'b1, 3'd3, 10'd0, 3'd0, 3'b111, 1'b0, 1'b0);
    idle(3'b111);
    chk(pc_o, 10'h004, "R8 external vector");
    chk(gie_o, 0, "R10 gie cleared");
    cycle(1'b1, 3'd4, 10'd0, 3'd0, 3'b111, 1'b0, 1'b0);
    chk(pc_o, 10'h131, "R11 return address");
    chk(gie_o, 1, "R11 gie set");

    // R9: priority with all three pending
    cycle(1'b0, 3'd0, 10'd0, 3'd0, 3'b111, 1'b0, 1'b1);
    cycle(1'b0, 3'd0, 10'd0, 3'b111, 3'b111, 1'b0, 1'b0);
    cycle(1'b0, 3'd0, 10'd0, 3'd0, 3'b111, 1'b1, 1'b0);
    idle(3'b111);
    chk(pc_o, 10'h004, "R9 external first");
    cycle(1'b1, 3'd4, 10'd0, 3'd0, 3'b111, 1'b0, 1'b0);
    idle(3'b111);
    chk(pc_o, 10'h008, "R9 timer second");
    cycle(1'b1, 3'd4, 10'd0, 3'd0, 3'b111, 1'b0, 1'b0);
    idle(3'b111);
    chk(pc_o, 10'h00C, "R9 conversion third");
    cycle(1'b1, 3'd4, 10'd0, 3'd0, 3'b111, 1'b0, 1'b0);

    // R12: clear wins over set
    cycle(1'b0, 3'd0, 10'd0, 3'd0, 3'd0, 1'b1, 1'b1);
    chk(gie_o, 0, "R12 clear over set");

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic       v;
      logic [2:0] op, req, en;
      v   = ($urandom % 4) != 0;
      op  = 3'($urandom % 8);
      req = 3'd0;
      for (int b = 0; b < 3; b++) if ($urandom % 16 == 0) req[b] = 1'b1;
      en  = ($urandom % 4 == 0) ? 3'($urandom) : 3'b111;
      cycle(v, op, 10'($urandom), req, en,
            ($urandom % 8) == 0, ($urandom % 16) == 0);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule